// File: doc/BRIEF.md
# Host-to-DSP Word Port with Command Requests

This block joins a byte-wide host processor to a DSP core when the two run from unrelated clocks. The host sees a small register file: a status byte, a command-vector byte, a command byte whose bit 0 is the request bit, and two data bytes (high and low) that act as transmit registers when written and receive registers when read. The DSP sees a word-wide receive register with a full flag and a take strobe, a word-wide transmit register with a load strobe and an empty flag, a few status inputs that it drives toward the host, and an exception request with its vector.

Words move in both directions under a toggle handshake, so that a multi-bit value is never sampled while it changes. Status bits that the DSP drives go through a two-flop synchronizer per bit in the host clock. Because each bit is synchronized on its own, a two-bit flag pair that changes in both bits at once can be read torn for one host cycle. Host software must read the pair twice and act only when the two reads agree. A host command raises an exception request at the DSP with the stored vector. The host can withdraw it until the DSP answers with a one-cycle accept pulse, and that pulse clears the request bit on the host side.

Top module: `host_dsp_port`

## Requirements
- R1: After reset the status byte reads 0x06: bit 1 (transmit empty) and bit 2 (transmitter ready) are set and all other bits are clear. The DSP transmit-empty output is 1, and the DSP receive-full output and the exception request are 0.
- R2: Writing the high byte (address 4) and then the low byte (address 5) while transmit empty is set delivers the word {high, low} to the DSP receive register with receive-full set. Transmit empty reads 0 from the first host edge after the low-byte write.
- R3: Writes to address 4 or 5 while transmit empty is clear are ignored. No extra word reaches the DSP, and the word already in flight is unchanged.
- R4: Transmit empty sets again once the word has been loaded into the DSP receive register. Transmitter ready (status bit 2) is transmit empty AND'ed with a synchronized "DSP receive register empty".
- R5: A DSP load strobe while transmit-empty is 1 makes the word readable at addresses 4 and 5 and sets receive-full (status bit 0). The DSP transmit-empty output drops on the next DSP edge. A host read of address 5 clears receive-full, and a load strobe while transmit-empty is 0 is ignored.
- R6: The DSP host-request input appears at status bit 3 and the DMA-mode input at status bit 6 within three host edges of a change.
- R7: Flag inputs 0 and 1 appear at status bits 4 and 5 through separate synchronizers. A skewed 00 to 11 change can read as 01 for one host cycle, and two consecutive equal reads never return a torn value.
- R8: Writing 1 to bit 0 of the command byte (address 2) sets status bit 7 and raises the DSP exception request with the vector from address 1 (low 7 bits).
- R9: While the command bit is set, writes to the vector register (address 1) are ignored. Once the bit is clear they take effect.
- R10: Writing 0 to the command bit before the DSP accepts withdraws the exception request, so no exception is taken.
- R11: A DSP accept pulse while the request is high drops the request on the next DSP edge and clears the host command bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset, released per clock domain |
| h_clk | input | 1 | Host clock |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe (a low-byte read consumes receive data) |
| h_addr | input | 3 | Host register address |
| h_wdata | input | BW | Host write data |
| h_rdata | output | BW | Host read data, combinational from h_addr |
| d_clk | input | 1 | DSP clock |
| d_rx_word | output | 2*BW | Word received from the host |
| d_rx_full | output | 1 | DSP receive register holds a word |
| d_rx_take | input | 1 | DSP consumes the receive word |
| d_tx_word | input | 2*BW | Word to send to the host |
| d_tx_load | input | 1 | DSP loads d_tx_word |
| d_tx_empty | output | 1 | DSP may load a new word |
| d_flags | input | 2 | DSP-driven flag pair |
| d_hreq | input | 1 | DSP-driven host request status |
| d_dma | input | 1 | DSP-driven DMA-mode status |
| d_exc_req | output | 1 | Host command exception request |
| d_exc_vec | output | VW | Exception vector |
| d_exc_ack | input | 1 | One-cycle accept pulse from the DSP |

## Verification
Effects local to one side are due at the first edge of that side's clock: the transmit-empty drop after a low-byte write, the receive-full clear after a low-byte read, ignored writes, the DSP transmit-empty drop and the request drop after an accept. The bench samples these at the falling edge that follows. Synchronized status bits are due after the second host edge following the change, so they are sampled after three or four host cycles. Word deliveries and the command request need two edges in each domain. The bench polls those with bounded loops, and a scoreboard queue compares the words in order. The torn-flag case is made on purpose by skewing the two flag inputs one host cycle apart, with the status byte sampled every host cycle.

// File: rtl/hd_pkg.sv
package hd_pkg;
  typedef enum logic [2:0] {
    HA_STAT = 3'd0,
    HA_VEC  = 3'd1,
    HA_CMD  = 3'd2,
    HA_HI   = 3'd4,
    HA_LO   = 3'd5
  } hd_addr_e;

  localparam int ST_RXF  = 0;
  localparam int ST_TXE  = 1;
  localparam int ST_TRDY = 2;
  localparam int ST_HREQ = 3;
  localparam int ST_FL0  = 4;
  localparam int ST_FL1  = 5;
  localparam int ST_DMA  = 6;
  localparam int ST_CMD  = 7;
  localparam int ST_W    = 8;
  localparam int SYNC_W  = 5;
endpackage

// File: rtl/hd_sync.sv
module hd_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/hd_rst_sync.sv
module hd_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_o = stage_q[1];
endmodule

// File: rtl/hd_xfer.sv
module hd_xfer #(
  parameter int W = 16
) (
  input  logic         s_clk,
  input  logic         s_rst_n,
  input  logic         s_load,
  input  logic [W-1:0] s_data,
  output logic         s_empty,
  input  logic         d_clk,
  input  logic         d_rst_n,
  input  logic         d_take,
  output logic [W-1:0] d_data,
  output logic         d_full
);
  logic [W-1:0] hold_q, hold_d;
  logic         req_q, req_d, ack_s;
  logic         req_s, seen_q, seen_d, full_q, full_d;
  logic [W-1:0] dat_q, dat_d;
  logic         s_go, d_go;

  hd_sync #(.W(1)) u_ack_sync (.clk(s_clk), .rst_n(s_rst_n), .d(seen_q), .q(ack_s));
  hd_sync #(.W(1)) u_req_sync (.clk(d_clk), .rst_n(d_rst_n), .d(req_q), .q(req_s));

  // source side: hold register is frozen until the destination has copied it
  assign s_empty = (req_q == ack_s);
  assign s_go    = s_load & s_empty;

  always_comb begin
    hold_d = hold_q;
    req_d  = req_q;
    if (s_go) begin
      hold_d = s_data;
      req_d  = ~req_q;
    end
  end

  always_ff @(posedge s_clk or negedge s_rst_n) begin
    if (!s_rst_n) begin
      hold_q <= '0;
      req_q  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      req_q  <= req_d;
    end
  end

  // destination side: copy only when a new toggle is seen and the register is free
  assign d_go = (req_s != seen_q) & ~full_q;

  always_comb begin
    seen_d = seen_q;
    full_d = full_q;
    dat_d  = dat_q;
    if (d_take) full_d = 1'b0;
    if (d_go) begin
      dat_d  = hold_q;
      seen_d = req_s;
      full_d = 1'b1;
    end
  end

  always_ff @(posedge d_clk or negedge d_rst_n) begin
    if (!d_rst_n) begin
      seen_q <= 1'b0;
      full_q <= 1'b0;
      dat_q  <= '0;
    end else begin
      seen_q <= seen_d;
      full_q <= full_d;
      dat_q  <= dat_d;
    end
  end

  assign d_data = dat_q;
  assign d_full = full_q;
endmodule

// File: rtl/host_dsp_port.sv
module host_dsp_port
  import hd_pkg::*;
#(
  parameter int BW = 8,
  parameter int VW = 7
) (
  input  logic            rst_n,
  input  logic            h_clk,
  input  logic            h_wr,
  input  logic            h_rd,
  input  logic [2:0]      h_addr,
  input  logic [BW-1:0]   h_wdata,
  output logic [BW-1:0]   h_rdata,
  input  logic            d_clk,
  output logic [2*BW-1:0] d_rx_word,
  output logic            d_rx_full,
  input  logic            d_rx_take,
  input  logic [2*BW-1:0] d_tx_word,
  input  logic            d_tx_load,
  output logic            d_tx_empty,
  input  logic [1:0]      d_flags,
  input  logic            d_hreq,
  input  logic            d_dma,
  output logic            d_exc_req,
  output logic [VW-1:0]   d_exc_vec,
  input  logic            d_exc_ack
);
  localparam int WW = 2 * BW;

  logic h_rstn, d_rstn;
  hd_rst_sync u_hrst (.clk(h_clk), .arst_n(rst_n), .rst_n_o(h_rstn));
  hd_rst_sync u_drst (.clk(d_clk), .arst_n(rst_n), .rst_n_o(d_rstn));

  logic          wr_hi, wr_lo, wr_vec, wr_cmd, rd_lo;
  logic          txde, rxdf;
  logic [BW-1:0] txh_q, txh_d;
  logic [WW-1:0] rx_word;

  assign wr_hi  = h_wr && (h_addr == HA_HI);
  assign wr_lo  = h_wr && (h_addr == HA_LO);
  assign wr_vec = h_wr && (h_addr == HA_VEC);
  assign wr_cmd = h_wr && (h_addr == HA_CMD);
  assign rd_lo  = h_rd && (h_addr == HA_LO);

  // host -> DSP word path; a low-byte write launches the transfer
  hd_xfer #(.W(WW)) u_h2d (
    .s_clk(h_clk), .s_rst_n(h_rstn), .s_load(wr_lo), .s_data({txh_q, h_wdata}),
    .s_empty(txde), .d_clk(d_clk), .d_rst_n(d_rstn), .d_take(d_rx_take),
    .d_data(d_rx_word), .d_full(d_rx_full)
  );

  // DSP -> host word path; a low-byte read consumes it
  hd_xfer #(.W(WW)) u_d2h (
    .s_clk(d_clk), .s_rst_n(d_rstn), .s_load(d_tx_load), .s_data(d_tx_word),
    .s_empty(d_tx_empty), .d_clk(h_clk), .d_rst_n(h_rstn), .d_take(rd_lo),
    .d_data(rx_word), .d_full(rxdf)
  );

  // per-bit status synchronizers: {dma, flag1, flag0, hreq, dsp_rx_full}
  logic [SYNC_W-1:0] st_raw, st_s;
  assign st_raw = {d_dma, d_flags, d_hreq, d_rx_full};
  hd_sync #(.W(SYNC_W)) u_st_sync (.clk(h_clk), .rst_n(h_rstn), .d(st_raw), .q(st_s));

  // host command request and its vector
  logic          cmd_q, cmd_d, ack_seen_q, ack_seen_d, ack_s;
  logic [VW-1:0] vec_q, vec_d;
  logic          acc_tg_q, acc_tg_d, done_q, done_d, cmd_s, d_accept;

  hd_sync #(.W(1)) u_acc_sync (.clk(h_clk), .rst_n(h_rstn), .d(acc_tg_q), .q(ack_s));
  hd_sync #(.W(1)) u_cmd_sync (.clk(d_clk), .rst_n(d_rstn), .d(cmd_q), .q(cmd_s));

  always_comb begin
    txh_d      = txh_q;
    cmd_d      = cmd_q;
    vec_d      = vec_q;
    ack_seen_d = ack_seen_q;
    if (wr_hi && txde)    txh_d = h_wdata;
    if (wr_vec && !cmd_q) vec_d = h_wdata[VW-1:0];
    if (wr_cmd)           cmd_d = h_wdata[0];
    if (ack_s != ack_seen_q) begin
      ack_seen_d = ack_s;
      cmd_d      = 1'b0;
    end
  end

  always_ff @(posedge h_clk or negedge h_rstn) begin
    if (!h_rstn) begin
      txh_q      <= '0;
      cmd_q      <= 1'b0;
      vec_q      <= '0;
      ack_seen_q <= 1'b0;
    end else begin
      txh_q      <= txh_d;
      cmd_q      <= cmd_d;
      vec_q      <= vec_d;
      ack_seen_q <= ack_seen_d;
    end
  end

  assign d_accept = d_exc_ack & d_exc_req;

  always_comb begin
    acc_tg_d = acc_tg_q;
    done_d   = done_q;
    if (d_accept) begin
      acc_tg_d = ~acc_tg_q;
      done_d   = 1'b1;
    end else if (!cmd_s) begin
      done_d = 1'b0;
    end
  end

  always_ff @(posedge d_clk or negedge d_rstn) begin
    if (!d_rstn) begin
      acc_tg_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      acc_tg_q <= acc_tg_d;
      done_q   <= done_d;
    end
  end

  assign d_exc_req = cmd_s & ~done_q;
  assign d_exc_vec = vec_q;

  // host read mux
  logic [ST_W-1:0] status;
  always_comb begin
    status          = '0;
    status[ST_RXF]  = rxdf;
    status[ST_TXE]  = txde;
    status[ST_TRDY] = txde & ~st_s[0];
    status[ST_HREQ] = st_s[1];
    status[ST_FL0]  = st_s[2];
    status[ST_FL1]  = st_s[3];
    status[ST_DMA]  = st_s[4];
    status[ST_CMD]  = cmd_q;
  end

  always_comb begin
    case (h_addr)
      HA_STAT: h_rdata = BW'(status);
      HA_VEC:  h_rdata = BW'(vec_q);
      HA_CMD:  h_rdata = BW'(cmd_q);
      HA_HI:   h_rdata = rx_word[WW-1:BW];
      HA_LO:   h_rdata = rx_word[BW-1:0];
      default: h_rdata = '0;
    endcase
  end
endmodule

// File: rtl/hd_port_chk.sv
module hd_port_chk
  import hd_pkg::*;
#(
  parameter int BW = 8,
  parameter int VW = 7
) (
  input logic            h_clk,
  input logic            h_rstn,
  input logic            d_clk,
  input logic            d_rstn,
  input logic            h_wr,
  input logic            h_rd,
  input logic [2:0]      h_addr,
  input logic            txde,
  input logic            rxdf,
  input logic            cmd_q,
  input logic [VW-1:0]   vec_q,
  input logic [BW-1:0]   txh_q,
  input logic [2*BW-1:0] rx_word,
  input logic [2*BW-1:0] d_rx_word,
  input logic            d_rx_full,
  input logic            d_rx_take,
  input logic            d_tx_load,
  input logic            d_tx_empty,
  input logic            d_exc_req,
  input logic            d_exc_ack
);
  a_r2_txde_clears: assert property (@(posedge h_clk) disable iff (!h_rstn)
    (h_wr && h_addr == HA_LO && txde) |=> !txde);

  a_r2_rx_word_held: assert property (@(posedge d_clk) disable iff (!d_rstn)
    (d_rx_full && !d_rx_take) |=> (d_rx_full && $stable(d_rx_word)));

  a_r3_high_ignored: assert property (@(posedge h_clk) disable iff (!h_rstn)
    (h_wr && h_addr == HA_HI && !txde) |=> $stable(txh_q));

  a_r5_dtx_clears: assert property (@(posedge d_clk) disable iff (!d_rstn)
    (d_tx_load && d_tx_empty) |=> !d_tx_empty);

  a_r5_host_rx_held: assert property (@(posedge h_clk) disable iff (!h_rstn)
    (rxdf && !(h_rd && h_addr == HA_LO)) |=> (rxdf && $stable(rx_word)));

  a_r9_vec_frozen: assert property (@(posedge h_clk) disable iff (!h_rstn)
    cmd_q |=> $stable(vec_q));

  a_r11_req_drops: assert property (@(posedge d_clk) disable iff (!d_rstn)
    (d_exc_ack && d_exc_req) |=> !d_exc_req);
endmodule

bind host_dsp_port hd_port_chk #(.BW(BW), .VW(VW)) u_chk (
  .h_clk(h_clk), .h_rstn(h_rstn), .d_clk(d_clk), .d_rstn(d_rstn),
  .h_wr(h_wr), .h_rd(h_rd), .h_addr(h_addr), .txde(txde), .rxdf(rxdf),
  .cmd_q(cmd_q), .vec_q(vec_q), .txh_q(txh_q), .rx_word(rx_word),
  .d_rx_word(d_rx_word), .d_rx_full(d_rx_full), .d_rx_take(d_rx_take),
  .d_tx_load(d_tx_load), .d_tx_empty(d_tx_empty), .d_exc_req(d_exc_req),
  .d_exc_ack(d_exc_ack)
);

// File: tb/test_host_dsp_port.sv
`timescale 1ns/1ps
module test_host_dsp_port;
  import hd_pkg::*;
  localparam int BW = 8;
  localparam int VW = 7;
  localparam int WW = 16;

  logic rst_n, h_clk, d_clk, h_wr, h_rd;
  logic [2:0] h_addr;
  logic [BW-1:0] h_wdata, h_rdata;
  logic [WW-1:0] d_rx_word, d_tx_word;
  logic d_rx_full, d_rx_take, d_tx_load, d_tx_empty;
  logic [1:0] d_flags;
  logic d_hreq, d_dma, d_exc_req, d_exc_ack;
  logic [VW-1:0] d_exc_vec;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit auto_take = 1;
  logic [WW-1:0] exp_q[$];
  logic [WW-1:0] mon_e;

  initial h_clk = 0;
  always #4 h_clk = ~h_clk;
  initial d_clk = 0;
  always #5.5 d_clk = ~d_clk;

  host_dsp_port #(.BW(BW), .VW(VW)) i_host_dsp_port (
    .rst_n(rst_n), .h_clk(h_clk), .h_wr(h_wr), .h_rd(h_rd), .h_addr(h_addr),
    .h_wdata(h_wdata), .h_rdata(h_rdata), .d_clk(d_clk), .d_rx_word(d_rx_word),
    .d_rx_full(d_rx_full), .d_rx_take(d_rx_take), .d_tx_word(d_tx_word),
    .d_tx_load(d_tx_load), .d_tx_empty(d_tx_empty), .d_flags(d_flags),
    .d_hreq(d_hreq), .d_dma(d_dma), .d_exc_req(d_exc_req), .d_exc_vec(d_exc_vec),
    .d_exc_ack(d_exc_ack)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic host_wr(input logic [2:0] a, input logic [BW-1:0] v);
    @(negedge h_clk);
    h_addr = a; h_wdata = v; h_wr = 1'b1;
    @(negedge h_clk);
    h_wr = 1'b0;
  endtask

  task automatic host_rd(input logic [2:0] a, output logic [BW-1:0] v);
    @(negedge h_clk);
    h_addr = a; h_rd = 1'b1;
    #1 v = h_rdata;
    @(negedge h_clk);
    h_rd = 1'b0;
  endtask

  task automatic wait_bit(input int idx, input bit val, output bit ok);
    logic [BW-1:0] st;
    ok = 0;
    for (int i = 0; i < 200; i++) begin
      host_rd(HA_STAT, st);
      if (st[idx] == val) begin ok = 1; break; end
    end
  endtask

  // driver: pushes the expected word, then writes high and low bytes
  task automatic send_word(input logic [WW-1:0] w);
    bit ok;
    logic [BW-1:0] st;
    wait_bit(ST_TXE, 1'b1, ok);
    chk(ok, "R4 transmit empty before send", {31'd0, ok}, 1);
    exp_q.push_back(w);
    host_wr(HA_HI, w[15:8]);
    host_wr(HA_LO, w[7:0]);
    #1 st = h_rdata;
    host_rd(HA_STAT, st);
    chk(st[ST_TXE] == 1'b0, "R2 transmit empty clears after low write", st, 0);
  endtask

  task automatic dsp_send(input logic [WW-1:0] w);
    @(negedge d_clk);
    for (int i = 0; i < 200 && !d_tx_empty; i++) @(negedge d_clk);
    d_tx_word = w; d_tx_load = 1'b1;
    @(negedge d_clk);
    d_tx_load = 1'b0;
    chk(d_tx_empty == 1'b0, "R5 DSP transmit empty drops", d_tx_empty, 0);
  endtask

  task automatic host_recv(input logic [WW-1:0] w);
    bit ok;
    logic [BW-1:0] hi, lo, st;
    wait_bit(ST_RXF, 1'b1, ok);
    chk(ok, "R5 receive full sets", {31'd0, ok}, 1);
    host_rd(HA_HI, hi);
    host_rd(HA_LO, lo);
    chk({hi, lo} == w, "R5 word to host", {hi, lo}, w);
    host_rd(HA_STAT, st);
    chk(st[ST_RXF] == 1'b0, "R5 low read clears receive full", st, 0);
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < 400 && exp_q.size() != 0; i++) @(negedge d_clk);
    chk(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  // monitor: pops the scoreboard whenever the DSP receive register fills
  initial begin
    d_rx_take = 1'b0;
    forever begin
      @(negedge d_clk);
      if (auto_take && d_rx_full) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3 unexpected word at DSP", d_rx_word, 0);
        end else begin
          mon_e = exp_q.pop_front();
          chk(d_rx_word == mon_e, "R2 word to DSP", d_rx_word, mon_e);
        end
        d_rx_take = 1'b1;
        @(negedge d_clk);
        d_rx_take = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge h_clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [BW-1:0] st, v, a, b;
    logic [1:0] seq[8];
    bit ok, torn, bad, seen_req;
    rst_n = 0; h_wr = 0; h_rd = 0; h_addr = '0; h_wdata = '0;
    d_tx_word = '0; d_tx_load = 0; d_flags = 2'b00; d_hreq = 0; d_dma = 0; d_exc_ack = 0;
    repeat (5) @(negedge h_clk);
    rst_n = 1;
    repeat (8) @(negedge h_clk);

    // R1 reset state
    host_rd(HA_STAT, st);
    chk(st == 8'h06, "R1 status after reset", st, 8'h06);
    chk(d_tx_empty == 1'b1, "R1 DSP transmit empty", d_tx_empty, 1);
    chk(d_rx_full == 1'b0, "R1 DSP receive full", d_rx_full, 0);
    chk(d_exc_req == 1'b0, "R1 exception request", d_exc_req, 0);

    // R2 word integrity host to DSP
    send_word(16'hA55A);
    send_word(16'h0001);
    send_word(16'hFFFF);
    send_word(16'h8000);
    drain("R2 all words delivered");

    // R4 transmit empty and transmitter ready with DSP register held full
    auto_take = 0;
    send_word(16'h3C3C);
    wait_bit(ST_TXE, 1'b1, ok);
    chk(ok, "R4 transmit empty after DSP load", {31'd0, ok}, 1);
    repeat (6) @(negedge h_clk);
    host_rd(HA_STAT, st);
    chk(st[ST_TRDY] == 1'b0, "R4 transmitter ready low while DSP full", st, 0);

    // R3 writes while transmit empty is clear are ignored
    send_word(16'hC35A);
    host_wr(HA_HI, 8'hCC);
    host_wr(HA_LO, 8'hDD);
    repeat (20) @(negedge h_clk);
    host_rd(HA_STAT, st);
    chk(st[ST_TXE] == 1'b0, "R3 transmit empty stays clear", st, 0);
    auto_take = 1;
    drain("R3 queued words delivered");
    repeat (40) @(negedge d_clk);
    wait_bit(ST_TRDY, 1'b1, ok);
    chk(ok, "R4 transmitter ready returns", {31'd0, ok}, 1);

    // R5 DSP to host, including an ignored load
    dsp_send(16'h1234);
    @(negedge d_clk);
    d_tx_word = 16'hBEEF; d_tx_load = 1'b1;
    @(negedge d_clk);
    d_tx_load = 1'b0;
    host_recv(16'h1234);
    repeat (30) @(negedge h_clk);
    host_rd(HA_STAT, st);
    chk(st[ST_RXF] == 1'b0, "R5 load while not empty ignored", st, 0);
    chk(d_tx_empty == 1'b1, "R5 DSP transmit empty returns", d_tx_empty, 1);
    dsp_send(16'h00FF);
    host_recv(16'h00FF);
    dsp_send(16'hFF00);
    host_recv(16'hFF00);

    // R6 host request and DMA status
    @(negedge d_clk);
    d_hreq = 1'b1; d_dma = 1'b1;
    repeat (4) @(negedge h_clk);
    host_rd(HA_STAT, st);
    chk(st[ST_HREQ] == 1'b1, "R6 host request visible", st, 8'h08);
    chk(st[ST_DMA] == 1'b1, "R6 DMA mode visible", st, 8'h40);
    @(negedge d_clk);
    d_hreq = 1'b0; d_dma = 1'b0;
    repeat (4) @(negedge h_clk);
    host_rd(HA_STAT, st);
    chk(st[ST_HREQ] == 1'b0 && st[ST_DMA] == 1'b0, "R6 status bits clear", st, 0);

    // R7 torn flag pair and read-twice consensus
    @(negedge h_clk);
    h_addr = HA_STAT;
    fork
      begin
        @(posedge h_clk); #1 d_flags = 2'b01;
        @(posedge h_clk); #1 d_flags = 2'b11;
      end
    join_none
    for (int i = 0; i < 8; i++) begin
      @(negedge h_clk);
      seq[i] = h_rdata[ST_FL1:ST_FL0];
    end
    torn = 0; bad = 0;
    for (int i = 0; i < 8; i++) if (seq[i] == 2'b01 || seq[i] == 2'b10) torn = 1;
    for (int i = 0; i < 7; i++)
      if (seq[i] == seq[i+1] && (seq[i] == 2'b01 || seq[i] == 2'b10)) bad = 1;
    chk(torn, "R7 single read can be torn", {31'd0, torn}, 1);
    chk(!bad, "R7 matching pair never torn", {31'd0, bad}, 0);
    a = 8'h00; b = 8'hFF;
    for (int i = 0; i < 20 && a[ST_FL1:ST_FL0] != b[ST_FL1:ST_FL0]; i++) begin
      host_rd(HA_STAT, a);
      host_rd(HA_STAT, b);
    end
    chk(a[ST_FL1:ST_FL0] == 2'b11, "R7 consensus value", a[ST_FL1:ST_FL0], 2'b11);
    d_flags = 2'b00;
    repeat (4) @(negedge h_clk);

    // R8 command request with vector
    host_wr(HA_VEC, 8'h2A);
    host_wr(HA_CMD, 8'h01);
    repeat (6) @(negedge d_clk);
    chk(d_exc_req == 1'b1, "R8 exception request raised", d_exc_req, 1);
    chk(d_exc_vec == 7'h2A, "R8 exception vector", d_exc_vec, 7'h2A);
    host_rd(HA_STAT, st);
    chk(st[ST_CMD] == 1'b1, "R8 command bit in status", st, 8'h80);

    // R9 vector frozen while command pending
    host_wr(HA_VEC, 8'h11);
    host_rd(HA_VEC, v);
    chk(v == 8'h2A, "R9 vector write ignored", v, 8'h2A);
    chk(d_exc_vec == 7'h2A, "R9 DSP vector unchanged", d_exc_vec, 7'h2A);

    // R11 accept pulse
    @(negedge d_clk);
    d_exc_ack = 1'b1;
    @(negedge d_clk);
    d_exc_ack = 1'b0;
    chk(d_exc_req == 1'b0, "R11 request drops after accept", d_exc_req, 0);
    repeat (10) @(negedge h_clk);
    host_rd(HA_CMD, v);
    chk(v[0] == 1'b0, "R11 command bit cleared by accept", v, 0);
    repeat (10) @(negedge d_clk);
    chk(d_exc_req == 1'b0, "R11 request stays low", d_exc_req, 0);
    host_wr(HA_VEC, 8'h11);
    host_rd(HA_VEC, v);
    chk(v == 8'h11, "R9 vector write after clear", v, 8'h11);

    // R10 cancel before acceptance
    host_wr(HA_CMD, 8'h01);
    ok = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge d_clk);
      if (d_exc_req) begin ok = 1; break; end
    end
    chk(ok, "R8 request seen before cancel", {31'd0, ok}, 1);
    host_wr(HA_CMD, 8'h00);
    repeat (6) @(negedge d_clk);
    seen_req = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge d_clk);
      if (d_exc_req) seen_req = 1;
    end
    chk(!seen_req, "R10 cancelled request withdrawn", {31'd0, seen_req}, 0);
    host_rd(HA_STAT, st);
    chk(st[ST_CMD] == 1'b0, "R10 command bit clear", st, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule